// File: doc/BRIEF.md
# Single-Channel Memory/I-O DMA Controller

This block is one DMA channel. It copies data between a memory location, held in a moving memory address register, and one I/O address that never changes. An 8-bit control word sets the unit size (byte or word) and whether the memory address goes up or down after each unit. It also sets the repeat bit, the direction, and a 4-bit code that picks what starts a transfer. Two more inputs complete the setup. An interrupt-enable bit combines with the repeat bit to choose sequential, repeat or idle operation. A single-address bit replaces the I/O side with an external device that is strobed by an active-low acknowledge output.

Software-side setup arrives as a load pulse. The pulse copies the start memory address and a 16-bit unit count into working registers and into shadow copies. Once the channel is enabled, every start request moves one unit over a simple request/acknowledge bus master port. In dual-address mode this takes a read cycle and then a write cycle. In single-address mode it takes one strobed cycle. When the count reaches zero, the channel either stops and may raise its end interrupt, or reloads from the shadows and keeps going.

Top module: `dmaChan`

## Requirements
- R1: After reset the bus request and the end interrupt are low, the acknowledge strobe `dackN` is high, and the memory address and count read zero. The control word `ctrl` is laid out as bit 7 size, bit 6 down-count, bit 5 repeat, bit 4 direction, and bits 3:0 start code.
- R2: `ctrl[7]`=0 moves bytes and steps the memory address by 1. `ctrl[7]`=1 moves words, raises `busWord`, and steps by 2.
- R3: `ctrl[6]`=0 increments the memory address after each unit, and `ctrl[6]`=1 decrements it.
- R4: With `singleAddr`=0, each unit is a read followed by a write. `ctrl[4]`=0 reads the memory address and writes the I/O address. `ctrl[4]`=1 reads the I/O address and writes the memory address. The written data equals the data read.
- R5: With `singleAddr`=1, each unit is one bus cycle at the memory address with `dackN` low. `ctrl[4]`=0 makes it a read. `ctrl[4]`=1 makes it a write of `devData`.
- R6: Each unit lowers the count by one. When repeat is off and the count reaches zero, the channel stops. `endIrq` rises only if `irqEn`=1.
- R7: Repeat mode (`ctrl[5]`=1, `irqEn`=0) reloads the memory address and the count from the values last loaded when the count reaches zero. It keeps running and never raises `endIrq`.
- R8: Idle mode (`ctrl[5]`=1, `irqEn`=1) keeps the memory address fixed. It stops at a count of zero and raises `endIrq`.
- R9: Start codes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 select `evt[0]` to `evt[3]`. Codes 4'b1000, 4'b1001 and 4'b1010 select `evt[4]` to `evt[6]`. All other codes, except those in R10 and R11, start nothing. Each selected pulse starts one unit, and pulses on unselected lines are ignored.
- R10: Start code 4'b0010 starts a unit whenever `dreqN` is low and the channel is idle, so a held request gives units 3 cycles apart.
- R11: Start code 4'b0001 starts one unit per falling edge of `dreqN`. The first request after enabling is taken as a level, so a `dreqN` already low at enable starts one unit. Keeping it low starts no more.
- R12: Driving `chanEn` low clears `endIrq` and drops pending requests. No bus cycle begins unless the channel was enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrl | input | 8 | Control word (size, down, repeat, direction, start code) |
| irqEn | input | 1 | End-interrupt enable, also selects idle mode with repeat |
| singleAddr | input | 1 | Single-address strobed mode |
| chanEn | input | 1 | Channel enable |
| loadCfg | input | 1 | Load start address and count into working and shadow registers |
| memAddrIn | input | AW | Start memory address |
| countIn | input | CW | Unit count |
| ioAddr | input | AW | Fixed I/O address |
| dreqN | input | 1 | External active-low request |
| evt | input | 7 | Peripheral event pulses |
| devData | input | 16 | Data from the strobed device |
| busReq | output | 1 | Bus cycle request |
| busWrite | output | 1 | Bus cycle is a write |
| busWord | output | 1 | Bus cycle is word sized |
| busAddr | output | AW | Bus address |
| busWdata | output | 16 | Bus write data |
| busRdata | input | 16 | Bus read data |
| busAck | input | 1 | Bus cycle completes this clock |
| dackN | output | 1 | Active-low device strobe |
| memAddr | output | AW | Current memory address |
| xferCount | output | CW | Remaining unit count |
| endIrq | output | 1 | Transfer-end interrupt |

## Verification
The bench sweeps every start code and pulses every event line that was not selected before it pulses the one that was. A design that decoded a code wrongly would either move data on a foreign event or stay silent. Repeat mode is run past its reload point. A design that did not restore the shadow address would write the third unit at the wrong address, and one that treated the mode as sequential would stop after two units. In edge mode the request is held low across enabling. A design that lost the first request as a level would move nothing, and one that treated the mode as level-sensitive would keep moving. The idle, single-address and down-count word cases check the exact addresses, data and strobe counts, which exposes any wrong step size, step sign or direction.

// File: rtl/dmaPkg.sv
package dmaPkg;
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_SINGLE} stateT;

  typedef struct packed {
    logic load;     // take start address and count
    logic capture;  // latch read data
    logic step;     // one unit finished
    logic reload;   // restore from shadows
  } pathStrobeT;
endpackage

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] ctrl,
  input  logic       irqEn,
  input  logic       singleAddr,
  input  logic       chanEn,
  input  logic       loadCfg,
  input  logic       dreqN,
  input  logic [6:0] evt,
  input  logic       busAck,
  input  logic       countIsOne,
  output pathStrobeT strobe,
  output stateT      state,
  output logic       busReq,
  output logic       busWrite,
  output logic       dackN,
  output logic       endIrq
);
  logic [3:0] factor;
  logic isEdge, isLevel, evtHit, edgeHit;
  logic dreqPrev, firstArm, reqPend, stopped;
  logic startNow, unitDone, finalUnit, repeatMode;

  assign factor     = ctrl[3:0];
  assign isEdge     = (factor == 4'b0001);
  assign isLevel    = (factor == 4'b0010);
  assign repeatMode = ctrl[5] && !irqEn;

  always_comb begin
    evtHit = 1'b0;
    if (factor[3:2] == 2'b01)
      evtHit = evt[{1'b0, factor[1:0]}];
    else if (factor[3:2] == 2'b10 && factor[1:0] != 2'b11)
      evtHit = evt[3'd4 + {1'b0, factor[1:0]}];
  end

  assign edgeHit   = isEdge && !dreqN && (dreqPrev || firstArm);
  assign startNow  = (state == S_IDLE) && chanEn && !stopped &&
                     (reqPend || (isLevel && !dreqN));
  assign unitDone  = busAck && (state == S_WRITE || state == S_SINGLE);
  assign finalUnit = unitDone && countIsOne;

  always_comb begin
    strobe.load    = loadCfg;
    strobe.capture = busAck && (state == S_READ);
    strobe.step    = unitDone;
    strobe.reload  = finalUnit && repeatMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      dreqPrev <= 1'b1;
      firstArm <= 1'b1;
      reqPend  <= 1'b0;
      stopped  <= 1'b0;
      endIrq   <= 1'b0;
    end else begin
      dreqPrev <= dreqN;
      if (!chanEn) begin
        firstArm <= 1'b1;
        reqPend  <= 1'b0;
        stopped  <= 1'b0;
        endIrq   <= 1'b0;
      end else begin
        if (edgeHit) firstArm <= 1'b0;
        reqPend <= (reqPend && !startNow) || edgeHit || evtHit;
        if (loadCfg) stopped <= 1'b0;
        else if (finalUnit && !repeatMode) stopped <= 1'b1;
        if (finalUnit && irqEn) endIrq <= 1'b1;
      end
      case (state)
        S_IDLE:   if (startNow) state <= singleAddr ? S_SINGLE : S_READ;
        S_READ:   if (busAck) state <= S_WRITE;
        S_WRITE:  if (busAck) state <= S_IDLE;
        S_SINGLE: if (busAck) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busReq   = (state != S_IDLE);
  assign busWrite = (state == S_WRITE) || (state == S_SINGLE && ctrl[4]);
  assign dackN    = (state != S_SINGLE);
endmodule

// File: rtl/dmaPath.sv
module dmaPath
  import dmaPkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  pathStrobeT    strobe,
  input  stateT         state,
  input  logic [7:0]    ctrl,
  input  logic          irqEn,
  input  logic [AW-1:0] memAddrIn,
  input  logic [CW-1:0] countIn,
  input  logic [AW-1:0] ioAddr,
  input  logic [15:0]   busRdata,
  input  logic [15:0]   devData,
  output logic [AW-1:0] busAddr,
  output logic [15:0]   busWdata,
  output logic [AW-1:0] memAddr,
  output logic [CW-1:0] xferCount,
  output logic          countIsOne
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [AW-1:0] shadowAddr, stepAmt;
  logic [CW-1:0] shadowCount;
  logic [15:0]   dataReg;
  logic          fixedAddr;

  assign stepAmt    = ctrl[7] ? AW'(2) : AW'(1);
  assign fixedAddr  = ctrl[5] && irqEn;
  assign countIsOne = (xferCount == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr     <= '0;
      shadowAddr  <= '0;
      xferCount   <= '0;
      shadowCount <= '0;
      dataReg     <= '0;
    end else begin
      if (strobe.capture) dataReg <= busRdata;
      if (strobe.load) begin
        memAddr     <= memAddrIn;
        shadowAddr  <= memAddrIn;
        xferCount   <= countIn;
        shadowCount <= countIn;
      end else if (strobe.reload) begin
        memAddr   <= shadowAddr;
        xferCount <= shadowCount;
      end else if (strobe.step) begin
        xferCount <= xferCount - ONE;
        if (!fixedAddr)
          memAddr <= ctrl[6] ? memAddr - stepAmt : memAddr + stepAmt;
      end
    end
  end

  always_comb begin
    case (state)
      S_READ:  busAddr = ctrl[4] ? ioAddr : memAddr;
      S_WRITE: busAddr = ctrl[4] ? memAddr : ioAddr;
      default: busAddr = memAddr;
    endcase
    busWdata = (state == S_SINGLE) ? devData : dataReg;
  end
endmodule

// File: rtl/dmaChan.sv
module dmaChan
  import dmaPkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [7:0]    ctrl,
  input  logic          irqEn,
  input  logic          singleAddr,
  input  logic          chanEn,
  input  logic          loadCfg,
  input  logic [AW-1:0] memAddrIn,
  input  logic [CW-1:0] countIn,
  input  logic [AW-1:0] ioAddr,
  input  logic          dreqN,
  input  logic [6:0]    evt,
  input  logic [15:0]   devData,
  output logic          busReq,
  output logic          busWrite,
  output logic          busWord,
  output logic [AW-1:0] busAddr,
  output logic [15:0]   busWdata,
  input  logic [15:0]   busRdata,
  input  logic          busAck,
  output logic          dackN,
  output logic [AW-1:0] memAddr,
  output logic [CW-1:0] xferCount,
  output logic          endIrq
);
  pathStrobeT strobe;
  stateT      state;
  logic       countIsOne;

  assign busWord = ctrl[7];

  dmaCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .irqEn(irqEn), .singleAddr(singleAddr),
    .chanEn(chanEn), .loadCfg(loadCfg), .dreqN(dreqN), .evt(evt), .busAck(busAck),
    .countIsOne(countIsOne), .strobe(strobe), .state(state), .busReq(busReq),
    .busWrite(busWrite), .dackN(dackN), .endIrq(endIrq)
  );

  dmaPath #(.AW(AW), .CW(CW)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .state(state), .ctrl(ctrl),
    .irqEn(irqEn), .memAddrIn(memAddrIn), .countIn(countIn), .ioAddr(ioAddr),
    .busRdata(busRdata), .devData(devData), .busAddr(busAddr), .busWdata(busWdata),
    .memAddr(memAddr), .xferCount(xferCount), .countIsOne(countIsOne)
  );
endmodule

// File: rtl/dmaChanChecker.sv
module dmaChanChecker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic [7:0]    ctrl,
  input logic          irqEn,
  input logic          singleAddr,
  input logic          chanEn,
  input logic          loadCfg,
  input logic          busReq,
  input logic          dackN,
  input logic [AW-1:0] memAddr,
  input logic [CW-1:0] xferCount,
  input logic          endIrq
);
  // R5: the strobe only appears in a single-address bus cycle
  p_dack_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    !dackN |-> (busReq && singleAddr));

  // R6: a raised end interrupt means the channel has stopped
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    endIrq |-> !busReq);

  // R2 / R3: a counted unit outside repeat mode moves the address by the unit size
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (xferCount == CW'($past(xferCount) - 1'b1) && !$past(loadCfg) && !$past(ctrl[5]))
    |-> (memAddr == ($past(ctrl[6])
                     ? AW'($past(memAddr) - ($past(ctrl[7]) ? 2 : 1))
                     : AW'($past(memAddr) + ($past(ctrl[7]) ? 2 : 1)))));

  // R8: idle mode never moves the memory address
  p_idle_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl[5] && irqEn && !loadCfg) |=> $stable(memAddr));

  // R12: bus cycles begin only on an enabled channel
  p_start_enabled_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(chanEn));
endmodule

bind dmaChan dmaChanChecker #(.AW(AW), .CW(CW)) uChk (
  .clk(clk), .rstN(rstN), .ctrl(ctrl), .irqEn(irqEn), .singleAddr(singleAddr),
  .chanEn(chanEn), .loadCfg(loadCfg), .busReq(busReq), .dackN(dackN),
  .memAddr(memAddr), .xferCount(xferCount), .endIrq(endIrq)
);

// File: tb/test_dmaChan.sv
`timescale 1ns/1ps
module test_dmaChan;
  localparam logic [15:0] IO = 16'h0F00;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ctrl = 8'h00;
  logic irqEn = 1'b0, singleAddr = 1'b0, chanEn = 1'b0, loadCfg = 1'b0;
  logic [15:0] memAddrIn = '0, countIn = '0;
  logic dreqN = 1'b1;
  logic [6:0] evt = '0;
  logic [15:0] devData = 16'hBEEF;
  logic busReq, busWrite, busWord, dackN, endIrq;
  logic [15:0] busAddr, busWdata, busRdata, memAddr, xferCount;
  logic busAck;

  int tests = 0, fails = 0;
  int cyc = 0;
  logic logClr = 1'b0;
  int wrN, rdN, sglN;
  logic [15:0] wrAddr [32];
  logic [15:0] wrData [32];
  int wrTime [32];
  logic wrWord;

  always #10 clk = ~clk;

  function automatic logic [15:0] rdModel(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ a[7:0]};
  endfunction

  assign busAck   = busReq;
  assign busRdata = rdModel(busAddr);

  dmaChan i_dmaChan (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .irqEn(irqEn), .singleAddr(singleAddr),
    .chanEn(chanEn), .loadCfg(loadCfg), .memAddrIn(memAddrIn), .countIn(countIn),
    .ioAddr(IO), .dreqN(dreqN), .evt(evt), .devData(devData), .busReq(busReq),
    .busWrite(busWrite), .busWord(busWord), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck), .dackN(dackN), .memAddr(memAddr),
    .xferCount(xferCount), .endIrq(endIrq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (logClr) begin
      wrN <= 0; rdN <= 0; sglN <= 0;
    end else if (busReq && busAck) begin
      if (busWrite) begin
        if (wrN < 32) begin
          wrAddr[wrN] <= busAddr;
          wrData[wrN] <= busWdata;
          wrTime[wrN] <= cyc;
        end
        wrWord <= busWord;
        wrN <= wrN + 1;
      end else rdN <= rdN + 1;
      if (!dackN) sglN <= sglN + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic setup(input logic [7:0] c, input logic ie, input logic sa,
                       input logic [15:0] ma, input logic [15:0] cnt);
    @(negedge clk);
    chanEn = 1'b0; ctrl = c; irqEn = ie; singleAddr = sa;
    memAddrIn = ma; countIn = cnt; loadCfg = 1'b1;
    @(negedge clk);
    loadCfg = 1'b0; logClr = 1'b1;
    @(negedge clk);
    logClr = 1'b0; chanEn = 1'b1;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); evt[idx] = 1'b1;
    @(negedge clk); evt[idx] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busReq", busReq, 0);
    check("R1 dackN", dackN, 1);
    check("R1 endIrq", endIrq, 0);
    check("R1 memAddr", memAddr, 0);
    check("R1 count", xferCount, 0);

    // R10 / R4 / R6: level request, byte, up-count, memory to I/O, interrupt on
    setup(8'h02, 1'b1, 1'b0, 16'h0100, 16'd4);
    dreqN = 1'b0;
    repeat (30) @(negedge clk);
    dreqN = 1'b1;
    check("R6 units", wrN, 4);
    check("R4 reads", rdN, 4);
    for (int i = 0; i < 4; i++) begin
      check("R4 wr addr", wrAddr[i], IO);
      check("R4 wr data", wrData[i], rdModel(16'h0100 + 16'(i)));
    end
    check("R10 spacing", wrTime[1] - wrTime[0], 3);
    check("R2 byte step", memAddr, 16'h0104);
    check("R6 count zero", xferCount, 0);
    check("R6 endIrq", endIrq, 1);
    // R12: disable clears the interrupt
    @(negedge clk); chanEn = 1'b0;
    @(negedge clk);
    check("R12 irq cleared", endIrq, 0);

    // R2 / R3 / R4: word, down-count, I/O to memory, no interrupt
    setup(8'hD2, 1'b0, 1'b0, 16'h0200, 16'd3);
    dreqN = 1'b0;
    repeat (25) @(negedge clk);
    dreqN = 1'b1;
    check("R6 units", wrN, 3);
    for (int i = 0; i < 3; i++) begin
      check("R3 wr addr", wrAddr[i], 16'h0200 - 16'(2 * i));
      check("R4 wr data", wrData[i], rdModel(IO));
    end
    check("R2 busWord", wrWord, 1);
    check("R3 final addr", memAddr, 16'h01FA);
    check("R6 no irq", endIrq, 0);

    // R9 / R7: sweep of event codes in repeat mode
    for (int f = 4; f <= 10; f++) begin
      setup({4'b0010, 4'(f)}, 1'b0, 1'b0, 16'h0300, 16'd2);
      for (int e = 0; e < 7; e++) if (e != f - 4) pulse(e);
      check("R9 foreign events ignored", wrN, 0);
      for (int k = 0; k < 3; k++) pulse(f - 4);
      check("R9 selected event units", wrN, 3);
      check("R7 data after reload", wrData[2], rdModel(16'h0300));
      check("R7 addr", memAddr, 16'h0301);
      check("R7 count", xferCount, 1);
      check("R7 no irq", endIrq, 0);
    end

    // R9: codes that start nothing
    for (int f = 0; f < 16; f++) begin
      if (f == 0 || f == 3 || f >= 11) begin
        setup({4'b0000, 4'(f)}, 1'b1, 1'b0, 16'h0380, 16'd2);
        for (int e = 0; e < 7; e++) pulse(e);
        dreqN = 1'b0; repeat (4) @(negedge clk);
        dreqN = 1'b1; repeat (2) @(negedge clk);
        dreqN = 1'b0; repeat (4) @(negedge clk);
        dreqN = 1'b1; repeat (2) @(negedge clk);
        check("R9 no-start code", wrN, 0);
      end
    end

    // R8: idle mode, word, fixed address
    setup(8'hA2, 1'b1, 1'b0, 16'h0400, 16'd2);
    dreqN = 1'b0;
    repeat (20) @(negedge clk);
    dreqN = 1'b1;
    check("R8 units", wrN, 2);
    check("R8 data 0", wrData[0], rdModel(16'h0400));
    check("R8 data 1", wrData[1], rdModel(16'h0400));
    check("R8 addr fixed", memAddr, 16'h0400);
    check("R8 irq", endIrq, 1);

    // R11: request already low at enable counts once
    dreqN = 1'b0;
    setup(8'h01, 1'b1, 1'b0, 16'h0500, 16'd3);
    repeat (20) @(negedge clk);
    check("R11 first level", wrN, 1);
    dreqN = 1'b1; repeat (2) @(negedge clk);
    dreqN = 1'b0; repeat (20) @(negedge clk);
    check("R11 edge", wrN, 2);
    // R11: high at enable, nothing until a fall
    dreqN = 1'b1;
    setup(8'h01, 1'b1, 1'b0, 16'h0500, 16'd3);
    repeat (10) @(negedge clk);
    check("R11 no request", wrN, 0);
    dreqN = 1'b0; repeat (10) @(negedge clk);
    check("R11 fall", wrN, 1);
    dreqN = 1'b1;

    // R5: single address, memory read with strobe
    setup(8'h02, 1'b0, 1'b1, 16'h0600, 16'd2);
    dreqN = 1'b0; repeat (12) @(negedge clk); dreqN = 1'b1;
    check("R5 reads", rdN, 2);
    check("R5 strobes", sglN, 2);
    check("R5 no writes", wrN, 0);
    check("R5 addr", memAddr, 16'h0602);

    // R5: single address, strobed device to memory, word
    setup(8'h92, 1'b0, 1'b1, 16'h0700, 16'd2);
    dreqN = 1'b0; repeat (12) @(negedge clk); dreqN = 1'b1;
    check("R5 writes", wrN, 2);
    check("R5 strobes", sglN, 2);
    check("R5 wr addr", wrAddr[1], 16'h0702);
    check("R5 wr data", wrData[0], 16'hBEEF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule